// File: doc/BRIEF.md
# Master Clock Ratio and Speed Detector

This block sits in the master clock domain of an audio converter. It measures how many master clock cycles fit in one period of the sample-rate frame clock, matches that count to one of seven legal ratios and, from the match, chooses the sampling speed (normal, double or quad) and the oversampling rate that the interpolator and modulator must run at. It also gates the de-emphasis request so that the filter is used only at normal speed.

The frame clock is asynchronous to the master clock. It passes through a synchronizer, and only its rising edges are used. The first rising edge after reset, or after a stop, only starts the period counter. Every later rising edge produces one period measurement. A ratio is committed only when two measurements in a row match the same legal ratio. When auto mode is off, the block always runs at normal speed and accepts only the ratios that normal speed supports. If no rising frame edge is seen for a long time, the block reports that the clocks have stopped and drops its valid flag until the frame clock returns. All outputs are plain level signals. There is no data stream, so there is no handshake.

Top module: `clkratio_detect`

## Requirements
- R1: On every rising frame edge after the first, the block measures the period in master clocks. When two consecutive measurements each fall within ±2 cycles of the same legal ratio, `ratio_code` is set to that ratio and `ratio_valid` goes high. The codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 and 6=1152.
- R2: With `auto_sel`=1, the speed follows the committed ratio: 512, 768 or 1152 give normal (`speed_mode`=2'b00), 256 or 384 give double (2'b01), and 128 or 192 give quad (2'b10).
- R3: With `auto_sel`=0, a committed ratio always gives normal speed. Counts near 128 or 192 are rejected as a mismatch.
- R4: `osr_rate` is 128 at normal speed, 64 at double speed and 32 at quad speed.
- R5: `deemph_en` is high only while `deemph_req`=1, `ratio_valid`=1 and the speed is normal. It is low at double and quad speed even when de-emphasis is requested.
- R6: A single legal measurement that differs from the committed ratio leaves `ratio_code`, `speed_mode` and `ratio_valid` unchanged.
- R7: A measurement that is more than 2 cycles from every accepted ratio clears `ratio_valid`.
- R8: When 2048 master clocks pass with no rising frame edge, `clk_stopped` goes high and `ratio_valid` goes low on the next cycle. The next rising edge clears `clk_stopped` and starts a new period without measuring.
- R9: After reset, `ratio_valid`, `clk_stopped` and `deemph_en` are 0, `speed_mode` is normal, `ratio_code` is 0 and `osr_rate` is 128. The first rising frame edge only starts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Sample-rate frame clock, asynchronous |
| auto_sel | input | 1 | 1: speed taken from the ratio; 0: forced normal speed |
| deemph_req | input | 1 | De-emphasis requested |
| speed_mode | output | 2 | 00 normal, 01 double, 10 quad |
| osr_rate | output | 8 | Oversampling factor: 128, 64 or 32 |
| ratio_code | output | 3 | Committed ratio code, as listed in R1 |
| ratio_valid | output | 1 | A committed ratio is current |
| deemph_en | output | 1 | Effective de-emphasis enable |
| clk_stopped | output | 1 | No rising frame edge for 2048 master clocks |

## Verification
A frame-clock rise that the bench drives before master edge k reaches the rise detector after the two synchronizer stages, at edge k+1. The period measurement is registered at edge k+2, and the committed ratio, speed, oversampling rate and valid flag change at edge k+3. `clk_stopped` rises at the 2048th edge after the edge that registered the last rise, and `ratio_valid` falls one edge later. `deemph_en` follows `deemph_req` in the same cycle. The reference model in the bench advances one step on every master edge and predicts each output for that edge. Outputs are compared a quarter period after the edge, so the stimulus, which is driven on the falling edge, never races the check. Directed checks run after whole frames, when every result is settled.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10
  } speed_e;

  localparam int NUM_RATIOS = 7;
  // lowest ratio index accepted when the speed is forced to normal
  localparam int MANUAL_MIN_IDX = 2;

  function automatic int unsigned ratio_value(input int unsigned idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

  function automatic speed_e speed_of(input logic [2:0] code, input logic auto_mode);
    if (!auto_mode)    return SPD_NORMAL;
    else if (code < 3'd2) return SPD_QUAD;
    else if (code < 3'd4) return SPD_DOUBLE;
    else               return SPD_NORMAL;
  endfunction

  function automatic logic [7:0] osr_of(input speed_e s);
    case (s)
      SPD_DOUBLE: return 8'd64;
      SPD_QUAD:   return 8'd32;
      default:    return 8'd128;
    endcase
  endfunction

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], async_in};
  end

  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int STOP_LIMIT = 2048,
  parameter int CNT_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_val,
  output logic             stopped
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STOP_LIMIT - 1);

  logic [CNT_W-1:0] cnt;
  logic             started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      started  <= 1'b0;
      stopped  <= 1'b0;
      meas_vld <= 1'b0;
      meas_val <= '0;
    end else begin
      meas_vld <= 1'b0;
      if (rise) begin
        cnt     <= '0;
        stopped <= 1'b0;
        started <= 1'b1;
        if (started) begin
          meas_vld <= 1'b1;
          meas_val <= cnt + 1'b1;
        end
      end else if (cnt == LAST) begin
        stopped <= 1'b1;
        started <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ratio_matcher.sv
module ratio_matcher #(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic             auto_mode,
  input  logic [CNT_W-1:0] meas_val,
  output logic             hit,
  output logic [2:0]       code
);
  import clkratio_pkg::*;

  logic [NUM_RATIOS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam int unsigned RV = ratio_value(i);
    localparam logic [CNT_W-1:0] LO = CNT_W'(RV - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(RV + TOL);
    localparam logic MAN_OK = (i >= MANUAL_MIN_IDX);
    assign hit_vec[i] = (meas_val >= LO) && (meas_val <= HI) && (auto_mode || MAN_OK);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit_vec[i]) code = 3'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/clkratio_detect.sv
module clkratio_detect #(
  parameter int STOP_LIMIT  = 2048,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       frame_clk,
  input  logic       auto_sel,
  input  logic       deemph_req,
  output logic [1:0] speed_mode,
  output logic [7:0] osr_rate,
  output logic [2:0] ratio_code,
  output logic       ratio_valid,
  output logic       deemph_en,
  output logic       clk_stopped
);
  import clkratio_pkg::*;

  localparam int CNT_W = $clog2(STOP_LIMIT) + 1;

  logic             rise;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_val;
  logic             hit;
  logic [2:0]       code;
  logic             cand_vld;
  logic [2:0]       cand_code;
  speed_e           speed_q;

  frame_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst_n(rst_n), .async_in(frame_clk), .rise(rise)
  );

  period_meter #(.STOP_LIMIT(STOP_LIMIT), .CNT_W(CNT_W)) u_meter (
    .clk(mclk), .rst_n(rst_n), .rise(rise),
    .meas_vld(meas_vld), .meas_val(meas_val), .stopped(clk_stopped)
  );

  ratio_matcher #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
    .auto_mode(auto_sel), .meas_val(meas_val), .hit(hit), .code(code)
  );

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_valid <= 1'b0;
      ratio_code  <= '0;
      speed_q     <= SPD_NORMAL;
      osr_rate    <= 8'd128;
      cand_vld    <= 1'b0;
      cand_code   <= '0;
    end else if (clk_stopped) begin
      ratio_valid <= 1'b0;
      cand_vld    <= 1'b0;
    end else if (meas_vld) begin
      if (hit) begin
        cand_vld  <= 1'b1;
        cand_code <= code;
        if (cand_vld && (cand_code == code)) begin
          ratio_valid <= 1'b1;
          ratio_code  <= code;
          speed_q     <= speed_of(code, auto_sel);
          osr_rate    <= osr_of(speed_of(code, auto_sel));
        end
      end else begin
        ratio_valid <= 1'b0;
        cand_vld    <= 1'b0;
      end
    end
  end

  assign speed_mode = speed_q;
  assign deemph_en  = deemph_req & ratio_valid & (speed_q == SPD_NORMAL);
endmodule

// File: rtl/clkratio_checks.sv
module clkratio_checks (
  input logic       mclk,
  input logic       rst_n,
  input logic       auto_sel,
  input logic [1:0] speed_mode,
  input logic [7:0] osr_rate,
  input logic [2:0] ratio_code,
  input logic       ratio_valid,
  input logic       deemph_en,
  input logic       clk_stopped
);
  AST_DEEMPH_GATED: assert property (@(posedge mclk) disable iff (!rst_n)
    deemph_en |-> (ratio_valid && speed_mode == 2'b00)); // R5
  AST_MANUAL_NORMAL: assert property (@(posedge mclk) disable iff (!rst_n)
    (ratio_valid && !$past(ratio_valid) && !$past(auto_sel)) |-> (speed_mode == 2'b00)); // R3
  AST_STOP_DROPS_VALID: assert property (@(posedge mclk) disable iff (!rst_n)
    clk_stopped |=> !ratio_valid); // R8
  AST_OSR_FOLLOWS_SPEED: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_valid |-> ((speed_mode == 2'b00 && osr_rate == 8'd128) ||
                     (speed_mode == 2'b01 && osr_rate == 8'd64) ||
                     (speed_mode == 2'b10 && osr_rate == 8'd32))); // R4
  AST_SPEED_ENCODING: assert property (@(posedge mclk) disable iff (!rst_n)
    speed_mode != 2'b11); // R2
  AST_CODE_RANGE: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_valid |-> (ratio_code < 3'd7)); // R1
endmodule

bind clkratio_detect clkratio_checks u_checks (
  .mclk(mclk), .rst_n(rst_n), .auto_sel(auto_sel), .speed_mode(speed_mode),
  .osr_rate(osr_rate), .ratio_code(ratio_code), .ratio_valid(ratio_valid),
  .deemph_en(deemph_en), .clk_stopped(clk_stopped)
);

// File: tb/clkratio_detect_bench.sv
module clkratio_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 2048;
  localparam int WATCHDOG   = 150000;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic       auto_sel = 1'b1;
  logic       deemph_req = 1'b0;
  logic [1:0] speed_mode;
  logic [7:0] osr_rate;
  logic [2:0] ratio_code;
  logic       ratio_valid;
  logic       deemph_en;
  logic       clk_stopped;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  clkratio_detect u_clkratio_detect (
    .mclk(mclk), .rst_n(rst_n), .frame_clk(frame_clk), .auto_sel(auto_sel),
    .deemph_req(deemph_req), .speed_mode(speed_mode), .osr_rate(osr_rate),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid), .deemph_en(deemph_en),
    .clk_stopped(clk_stopped)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  // ---------------- behavioural reference model ----------------
  int ratios[7] = '{128, 192, 256, 384, 512, 768, 1152};
  bit m_sh[3];
  int m_cnt, m_mval;
  bit m_started, m_stop, m_mvld;
  bit m_cvld;  int m_ccode;
  bit e_valid; int e_code, e_speed, e_osr;

  function automatic int classify(input int val, input bit am);
    for (int i = 0; i < 7; i++)
      if ((am || i >= 2) && val >= ratios[i] - 2 && val <= ratios[i] + 2) return i;
    return -1;
  endfunction

  function automatic int spd(input int code, input bit am);
    if (!am) return 0;
    if (code < 2) return 2;
    if (code < 4) return 1;
    return 0;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge mclk) begin
    bit rise; int c;
    cycles++;
    if (!rst_n) begin
      m_sh = '{0, 0, 0}; m_cnt = 0; m_mval = 0; m_started = 0; m_stop = 0; m_mvld = 0;
      m_cvld = 0; m_ccode = 0; e_valid = 0; e_code = 0; e_speed = 0; e_osr = 128;
    end else begin
      if (m_stop) begin
        e_valid = 0; m_cvld = 0;
      end else if (m_mvld) begin
        c = classify(m_mval, auto_sel);
        if (c >= 0) begin
          if (m_cvld && m_ccode == c) begin
            e_valid = 1; e_code = c; e_speed = spd(c, auto_sel);
            e_osr = (e_speed == 0) ? 128 : (e_speed == 1) ? 64 : 32;
          end
          m_cvld = 1; m_ccode = c;
        end else begin
          e_valid = 0; m_cvld = 0;
        end
      end
      rise = m_sh[1] && !m_sh[2];
      m_mvld = 0;
      if (rise) begin
        if (m_started) begin m_mvld = 1; m_mval = m_cnt + 1; end
        m_started = 1; m_stop = 0; m_cnt = 0;
      end else if (m_cnt == LIMIT - 1) begin
        m_stop = 1; m_started = 0;
      end else m_cnt++;
      m_sh[2] = m_sh[1]; m_sh[1] = m_sh[0]; m_sh[0] = frame_clk;
    end
    #(CLK_PERIOD/4);
    if (rst_n) begin
      cmp("R1 ratio_valid", ratio_valid, e_valid);
      cmp("R1 ratio_code", ratio_code, e_code);
      cmp("R2 speed_mode", speed_mode, e_speed);
      cmp("R4 osr_rate", osr_rate, e_osr);
      cmp("R5 deemph_en", deemph_en, deemph_req && e_valid && e_speed == 0);
      cmp("R8 clk_stopped", clk_stopped, m_stop);
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_frames(input int ratio, input int n);
    for (int f = 0; f < n; f++) begin
      frame_clk = 1'b1;
      repeat (ratio / 2) @(negedge mclk);
      frame_clk = 1'b0;
      repeat (ratio - ratio / 2) @(negedge mclk);
    end
  endtask

  initial begin
    repeat (4) @(negedge mclk);
    rst_n = 1'b1;
    @(negedge mclk);
    // R9 reset state
    cmp("R9 valid after reset", ratio_valid, 0);
    cmp("R9 stopped after reset", clk_stopped, 0);
    cmp("R9 osr after reset", osr_rate, 128);
    cmp("R9 speed after reset", speed_mode, 0);
    // R9 first edge only starts counting: one frame yields nothing
    run_frames(256, 1);
    cmp("R9 no measure on first edge", ratio_valid, 0);
    // R2 R4 R5 double speed, de-emphasis forced off
    deemph_req = 1'b1;
    run_frames(256, 5);
    cmp("R1 code 256", ratio_code, 2);
    cmp("R2 double", speed_mode, 1);
    cmp("R4 osr 64", osr_rate, 64);
    cmp("R5 deemph off at double", deemph_en, 0);
    // R2 R5 normal speed with de-emphasis
    run_frames(1152, 4);
    cmp("R2 normal", speed_mode, 0);
    cmp("R5 deemph on at normal", deemph_en, 1);
    deemph_req = 1'b0;
    @(negedge mclk);
    cmp("R5 deemph follows request", deemph_en, 0);
    // R2 quad
    run_frames(128, 5);
    cmp("R2 quad", speed_mode, 2);
    cmp("R4 osr 32", osr_rate, 32);
    // R1 tolerance accept, R7 reject
    run_frames(770, 4);
    cmp("R1 within tolerance", ratio_valid, 1);
    cmp("R1 code 768", ratio_code, 5);
    run_frames(773, 3);
    cmp("R7 out of tolerance", ratio_valid, 0);
    // R3 manual mode
    auto_sel = 1'b0;
    run_frames(192, 4);
    cmp("R3 manual rejects 192", ratio_valid, 0);
    run_frames(384, 4);
    cmp("R3 manual 384 valid", ratio_valid, 1);
    cmp("R3 manual 384 normal", speed_mode, 0);
    cmp("R3 manual osr", osr_rate, 128);
    auto_sel = 1'b1;
    // R6 single deviating frame is ignored
    run_frames(512, 4);
    run_frames(256, 1);
    run_frames(512, 1);
    cmp("R6 hold valid", ratio_valid, 1);
    cmp("R6 hold code", ratio_code, 4);
    // R8 stop detection
    repeat (1500) @(negedge mclk);
    cmp("R8 not yet stopped", clk_stopped, 0);
    repeat (700) @(negedge mclk);
    cmp("R8 stopped", clk_stopped, 1);
    cmp("R8 valid dropped", ratio_valid, 0);
    run_frames(512, 1);
    cmp("R8 stop cleared", clk_stopped, 0);
    cmp("R8 restart not measured", ratio_valid, 0);
    run_frames(512, 3);
    cmp("R8 recovered", ratio_valid, 1);
    repeat (5) @(negedge mclk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule